// File: doc/BRIEF.md
# Three-Channel Timer Unit Register Decoder

This block sits between a byte-addressed 32-bit register bus and up to three timer channels. It sorts each bus access into an address window and forwards it to the owning channel with that window's base already removed. It also holds two registers of its own: a run-control word whose low bits start and stop the channels, and a one-bit output-control register that exists only in builds that ask for it. The counting logic lives inside the channels. The decoder passes each channel's interrupt through to one output per channel.

The channel windows differ in size. Channel 0 owns 12 bytes, channel 1 owns 12 bytes and channel 2 owns everything from 0x20 upward. A build-time switch drops the third channel. In that build the upper window and the run bit of channel 2 become illegal. Each access is accepted whenever the decoder is ready, and it is answered on the next cycle, with no wait states. Illegal accesses read as zero, leave all state alone and raise an error flag on the answer.

Top module: `tmr_unit_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it, `rsp_valid`, `rsp_err`, `ch_run`, `ch_go`, `ch_halt` and `outctl_bit` are 0. `req_ready` is 0 during reset and 1 from the first clock edge after it.
- R2: Windows are decoded as follows, and the access raises exactly one bit of `ch_req` in its request cycle with `ch_off` set to the address minus the base:
  - 0x08..0x13 selects channel 0 (base 0x08).
  - 0x14..0x1F selects channel 1 (base 0x14).
  - 0x20 and above selects channel 2 (base 0x20).
  - Any other address raises no `ch_req` bit.
- R3: A read in a channel window returns that channel's `ch_rdata` slice (channel i at bits 32*i+31..32*i) on `rsp_rdata` in the response cycle. Bus write flag and write data are forwarded unchanged on `ch_write` and `ch_wdata`.
- R4: Offset 0x04 is the run-control word. Bit i drives `ch_run[i]`. A read returns the last written word, with all 32 bits kept except as R7 states.
- R5: After a run-control write, `ch_go[i]` is high for one cycle when bit i went from 0 to 1, and `ch_halt[i]` is high for one cycle when it went from 1 to 0. An unchanged bit pulses neither.
- R6: When the output-control feature is built, offset 0x00 keeps only bit 0 of a write, drives it on `outctl_bit`, and reads back zero-extended.
- R7: In a two-channel build, any access at 0x20 or above is an error that raises no `ch_req`. A run-control write with bit 2 set is an error: bits 0 and 1 still apply, and bit 2 is stored as 0.
- R8: Offsets 0x01..0x03, 0x05..0x07, and 0x00 in builds without output control, are unmapped. Reads return 0, writes change no state, and `rsp_err` is high for the one response cycle.
- R9: Every accepted request (`req_valid` and `req_ready`) gives `rsp_valid` for exactly one cycle on the next cycle. `rsp_valid` stays low in every other cycle. Any response with `rsp_err` carries `rsp_rdata` of 0.
- R10: `irq_out[i]` follows `ch_irq_in[i]` combinationally. `irq_out[2]` is 0 in a two-channel build.
- R11: `ch_capture_en` is set only for channel 2, and only when the third channel is built. `ch_extclk_en` holds the shared external-clock setting on every built channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Decoder accepts requests |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_err | output | 1 | Access was illegal or unmapped |
| rsp_rdata | output | DATA_W | Read data |
| ch_req | output | NUM_CH | Per-channel access strobe |
| ch_write | output | 1 | Forwarded write flag |
| ch_off | output | ADDR_W | Address relative to the channel base |
| ch_wdata | output | DATA_W | Forwarded write data |
| ch_rdata | input | NUM_CH*DATA_W | Per-channel read data, channel 0 lowest |
| ch_run | output | NUM_CH | Level run enable per channel |
| ch_go | output | NUM_CH | One-cycle start pulse |
| ch_halt | output | NUM_CH | One-cycle stop pulse |
| ch_capture_en | output | NUM_CH | Capture register present per channel |
| ch_extclk_en | output | NUM_CH | External-clock feature per channel |
| ch_irq_in | input | NUM_CH | Interrupt from each channel |
| irq_out | output | NUM_CH | Interrupt to the system per channel |
| outctl_bit | output | 1 | Output-control register value |

## Verification
The interesting overlap is the error flag and the run-control update landing on the same write. In a two-channel build, a run-control write with bit 2 set must flag an error and still start or stop channels 0 and 1 in that same cycle. The bench provokes this by driving one bus into a full three-channel instance and a reduced two-channel instance at once, cycling through run words where bit 2 toggles together with the lower bits. It judges each write from the response cycle: the error flag, the go and halt pulses and the run levels, and then the word read back.

// File: rtl/tmr_dec_pkg.sv
package tmr_dec_pkg;

  localparam int NUM_CH     = 3;
  localparam int OUTCTL_OFF = 'h00;
  localparam int START_OFF  = 'h04;
  localparam int CH0_BASE   = 'h08;
  localparam int CH1_BASE   = 'h14;
  localparam int CH2_BASE   = 'h20;

  typedef enum logic [2:0] {
    WIN_OUTCTL = 3'd0,
    WIN_START  = 3'd1,
    WIN_CH0    = 3'd2,
    WIN_CH1    = 3'd3,
    WIN_CH2    = 3'd4,
    WIN_NONE   = 3'd5
  } win_e;

  // Sort a byte address into its window; the upper window is descended first.
  function automatic win_e classify(input logic [31:0] a, input bit three_ch,
                                    input bit has_oc);
    if (a >= 32'(CH2_BASE)) return three_ch ? WIN_CH2 : WIN_NONE;
    if (a >= 32'(CH1_BASE)) return WIN_CH1;
    if (a >= 32'(CH0_BASE)) return WIN_CH0;
    if (a == 32'(START_OFF)) return WIN_START;
    if (a == 32'(OUTCTL_OFF) && has_oc) return WIN_OUTCTL;
    return WIN_NONE;
  endfunction

  function automatic logic [31:0] win_base(input win_e w);
    case (w)
      WIN_CH0: return 32'(CH0_BASE);
      WIN_CH1: return 32'(CH1_BASE);
      WIN_CH2: return 32'(CH2_BASE);
      default: return 32'd0;
    endcase
  endfunction

  function automatic win_e chan_win(input int idx);
    return win_e'(3'(int'(WIN_CH0) + idx));
  endfunction

  function automatic logic [NUM_CH-1:0] rise_bits(input logic [NUM_CH-1:0] old_v,
                                                  input logic [NUM_CH-1:0] new_v);
    return new_v & ~old_v;
  endfunction

  function automatic logic [NUM_CH-1:0] fall_bits(input logic [NUM_CH-1:0] old_v,
                                                  input logic [NUM_CH-1:0] new_v);
    return old_v & ~new_v;
  endfunction

endpackage

// File: rtl/tmr_win_decode.sv
module tmr_win_decode
  import tmr_dec_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter bit THREE_CH   = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic [ADDR_W-1:0] off,
  output logic [NUM_CH-1:0] hit
);

  always_comb begin
    win = classify(32'(addr), THREE_CH, HAS_OUTCTL);
    off = addr - ADDR_W'(win_base(win));
    if (win == WIN_NONE || win == WIN_START || win == WIN_OUTCTL) off = '0;
  end

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_hit
    assign hit[gi] = (win == chan_win(gi));
  end

endmodule

// File: rtl/tmr_start_ctrl.sv
module tmr_start_ctrl
  import tmr_dec_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit THREE_CH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word_q,
  output logic [NUM_CH-1:0] run,
  output logic [NUM_CH-1:0] go_pulse,
  output logic [NUM_CH-1:0] halt_pulse,
  output logic              bad_bit
);

  localparam logic [DATA_W-1:0] KEEP_MASK =
    THREE_CH ? {DATA_W{1'b1}} : ~(DATA_W'(1) << 2);

  logic [DATA_W-1:0] next_word;

  assign next_word = wdata & KEEP_MASK;
  assign bad_bit   = wr_en & wdata[2] & ~THREE_CH;
  assign run       = word_q[NUM_CH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q     <= '0;
      go_pulse   <= '0;
      halt_pulse <= '0;
    end else if (wr_en) begin
      word_q     <= next_word;
      go_pulse   <= rise_bits(run, next_word[NUM_CH-1:0]);
      halt_pulse <= fall_bits(run, next_word[NUM_CH-1:0]);
    end else begin
      go_pulse   <= '0;
      halt_pulse <= '0;
    end
  end

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chk
    p_go_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      go_pulse[gi] |-> (run[gi] && !$past(run[gi])));
    p_halt_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      halt_pulse[gi] |-> (!run[gi] && $past(run[gi])));
  end

  p_quiet_without_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (go_pulse == '0 && halt_pulse == '0 && $stable(word_q)));

  if (!THREE_CH) begin : g_two
    p_bit2_never_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !word_q[2]);
  end

endmodule

// File: rtl/tmr_outctl_reg.sv
module tmr_outctl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wbit,
  output logic bit_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bit_q <= 1'b0;
    else if (wr_en) bit_q <= wbit;
  end

  p_outctl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bit_q));

endmodule

// File: rtl/tmr_unit_decoder.sv
module tmr_unit_decoder
  import tmr_dec_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter bit THREE_CH   = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1,
  parameter bit EXT_CLK    = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic                     rsp_err,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [NUM_CH-1:0]        ch_req,
  output logic                     ch_write,
  output logic [ADDR_W-1:0]        ch_off,
  output logic [DATA_W-1:0]        ch_wdata,
  input  logic [NUM_CH*DATA_W-1:0] ch_rdata,
  output logic [NUM_CH-1:0]        ch_run,
  output logic [NUM_CH-1:0]        ch_go,
  output logic [NUM_CH-1:0]        ch_halt,
  output logic [NUM_CH-1:0]        ch_capture_en,
  output logic [NUM_CH-1:0]        ch_extclk_en,
  input  logic [NUM_CH-1:0]        ch_irq_in,
  output logic [NUM_CH-1:0]        irq_out,
  output logic                     outctl_bit
);

  localparam logic [NUM_CH-1:0] BUILT_MASK =
    THREE_CH ? {NUM_CH{1'b1}} : {1'b0, {(NUM_CH-1){1'b1}}};

  // Named internal events for the assertions
  logic              acc_fire;
  logic              start_wr;
  logic              bad_start;
  logic              err_now;
  win_e              win;
  logic [NUM_CH-1:0] hit;
  logic [DATA_W-1:0] start_word;
  logic [DATA_W-1:0] rd_now;
  logic              ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign req_ready = ready_q;
  assign acc_fire  = req_valid & ready_q;

  tmr_win_decode #(
    .ADDR_W    (ADDR_W),
    .THREE_CH  (THREE_CH),
    .HAS_OUTCTL(HAS_OUTCTL)
  ) u_decode (
    .addr(req_addr),
    .win (win),
    .off (ch_off),
    .hit (hit)
  );

  assign ch_req   = hit & {NUM_CH{acc_fire}};
  assign ch_write = req_write;
  assign ch_wdata = req_wdata;

  assign start_wr = acc_fire & req_write & (win == WIN_START);

  tmr_start_ctrl #(
    .DATA_W  (DATA_W),
    .THREE_CH(THREE_CH)
  ) u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (start_wr),
    .wdata     (req_wdata),
    .word_q    (start_word),
    .run       (ch_run),
    .go_pulse  (ch_go),
    .halt_pulse(ch_halt),
    .bad_bit   (bad_start)
  );

  if (HAS_OUTCTL) begin : g_oc
    logic oc_wr;
    assign oc_wr = acc_fire & req_write & (win == WIN_OUTCTL);
    tmr_outctl_reg u_outctl (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(oc_wr),
      .wbit (req_wdata[0]),
      .bit_q(outctl_bit)
    );
  end else begin : g_no_oc
    assign outctl_bit = 1'b0;
  end

  // Per-channel features and interrupt pass-through
  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    assign ch_capture_en[gi] = THREE_CH && (gi == NUM_CH-1);
    assign ch_extclk_en[gi]  = EXT_CLK && BUILT_MASK[gi];
    assign irq_out[gi]       = ch_irq_in[gi] & BUILT_MASK[gi];
  end

  assign err_now = (win == WIN_NONE) | bad_start;

  always_comb begin
    case (win)
      WIN_OUTCTL: rd_now = DATA_W'(outctl_bit);
      WIN_START:  rd_now = start_word;
      WIN_CH0:    rd_now = ch_rdata[0*DATA_W +: DATA_W];
      WIN_CH1:    rd_now = ch_rdata[1*DATA_W +: DATA_W];
      WIN_CH2:    rd_now = ch_rdata[2*DATA_W +: DATA_W];
      default:    rd_now = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_fire;
      rsp_err   <= acc_fire & err_now;
      rsp_rdata <= (acc_fire && !req_write && !err_now) ? rd_now : '0;
    end
  end

  p_rsp_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> rsp_valid);
  p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fire |=> !rsp_valid);
  p_err_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));
  p_one_channel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_req));
  p_err_no_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && err_now && !start_wr) |-> (ch_req == '0));

  if (!THREE_CH) begin : g_two_chk
    p_ch2_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_req[NUM_CH-1] && !ch_run[NUM_CH-1] && !irq_out[NUM_CH-1]));
  end

endmodule

// File: tb/test_tmr_unit_decoder.sv
`timescale 1ns/1ps
module test_tmr_unit_decoder;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [NC-1:0] irq_in = '0;

  // Instance A: three channels, output control, external clock
  logic rdyA, vA, eA, ocA, chwA;
  logic [DW-1:0] rdA, chwdA;
  logic [NC-1:0] reqA, runA, goA, haltA, capA, extA, irqA;
  logic [AW-1:0] offA;
  logic [NC*DW-1:0] chrdA;
  // Instance B: two channels, no output control, no external clock
  logic rdyB, vB, eB, ocB, chwB;
  logic [DW-1:0] rdB, chwdB;
  logic [NC-1:0] reqB, runB, goB, haltB, capB, extB, irqB;
  logic [AW-1:0] offB;
  logic [NC*DW-1:0] chrdB;

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      chrdA[i*DW +: DW] = 32'h5A00_0000 | (32'(i) << 16) | 32'(offA);
      chrdB[i*DW +: DW] = 32'h3C00_0000 | (32'(i) << 16) | 32'(offB);
    end
  end

  tmr_unit_decoder i_tmr_unit_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdyA),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(vA), .rsp_err(eA), .rsp_rdata(rdA), .ch_req(reqA),
    .ch_write(chwA), .ch_off(offA), .ch_wdata(chwdA), .ch_rdata(chrdA),
    .ch_run(runA), .ch_go(goA), .ch_halt(haltA), .ch_capture_en(capA),
    .ch_extclk_en(extA), .ch_irq_in(irq_in), .irq_out(irqA), .outctl_bit(ocA));

  tmr_unit_decoder #(.THREE_CH(1'b0), .HAS_OUTCTL(1'b0), .EXT_CLK(1'b0))
  i_tmr_unit_decoder_lite (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdyB),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(vB), .rsp_err(eB), .rsp_rdata(rdB), .ch_req(reqB),
    .ch_write(chwB), .ch_off(offB), .ch_wdata(chwdB), .ch_rdata(chrdB),
    .ch_run(runB), .ch_go(goB), .ch_halt(haltB), .ch_capture_en(capB),
    .ch_extclk_en(extB), .ch_irq_in(irq_in), .irq_out(irqB), .outctl_bit(ocB));

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  logic [DW-1:0] stA = '0, stB = '0;
  logic          ocm = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Channel index of an address, -1 when not a channel window
  function automatic int chan_of(input int a, input bit three);
    if (a >= 32) return three ? 2 : -1;
    if (a >= 20) return 1;
    if (a >= 8) return 0;
    return -1;
  endfunction

  function automatic int base_of(input int c);
    return (c == 0) ? 8 : (c == 1) ? 20 : 32;
  endfunction

  function automatic bit err_of(input int a, input bit three, input bit oc,
                                input bit wr, input logic [DW-1:0] d);
    if (chan_of(a, three) >= 0) return 1'b0;
    if (a == 4) return wr && !three && d[2];
    if (a == 0) return !oc;
    return 1'b1;
  endfunction

  // Expected read data for a read in the current model state
  function automatic logic [DW-1:0] rd_of(input int a, input bit three, input bit oc,
                                          input logic [DW-1:0] st, input logic [DW-1:0] pat);
    int c;
    c = chan_of(a, three);
    if (c >= 0) return pat | (32'(c) << 16) | 32'(a - base_of(c));
    if (a == 4) return st;
    if (a == 0 && oc) return 32'(ocm);
    return '0;
  endfunction

  task automatic access(input bit wr, input int a, input logic [DW-1:0] d,
                        output logic [DW-1:0] ra, output logic [DW-1:0] rb);
    int ca, cb;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    #1;
    ca = chan_of(a, 1'b1);
    cb = chan_of(a, 1'b0);
    chk(reqA == ((ca >= 0) ? NC'(1 << ca) : '0), "R2 ch_req A", 32'(reqA), 32'(a));
    chk(reqB == ((cb >= 0) ? NC'(1 << cb) : '0), "R7 ch_req B", 32'(reqB), 32'(a));
    if (ca >= 0) chk(offA == AW'(a - base_of(ca)), "R2 ch_off", 32'(offA), 32'(a - base_of(ca)));
    if (ca >= 0) chk(chwA == wr && chwdA == d, "R3 forward", chwdA, d);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(vA && vB, "R9 rsp_valid", 32'({vA, vB}), 32'd3);
    chk(eA == err_of(a, 1'b1, 1'b1, wr, d), "R8 err A", 32'(eA), 32'(err_of(a, 1'b1, 1'b1, wr, d)));
    chk(eB == err_of(a, 1'b0, 1'b0, wr, d), "R7 err B", 32'(eB), 32'(err_of(a, 1'b0, 1'b0, wr, d)));
    ra = rdA;
    rb = rdB;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] ra, rb, d, ea, eb;
    logic [NC-1:0] oldA, oldB, nA, nB;

    repeat (3) @(negedge clk);
    chk(!vA && !vB && !rdyA && !rdyB && runA == 0 && ocA == 0, "R1 in reset",
        32'({vA, vB, rdyA, rdyB}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdyA && rdyB, "R1 ready", 32'({rdyA, rdyB}), 32'd3);
    chk(!vA && !eA && runA == 0 && goA == 0 && haltA == 0 && ocA == 0 && runB == 0,
        "R1 after reset", 32'({vA, eA, runA, goA}), 0);
    @(negedge clk);
    chk(!vA && !vB, "R9 idle", 32'({vA, vB}), 0);

    // R11 features
    chk(capA == 3'b100 && extA == 3'b111, "R11 features A", 32'({capA, extA}), 32'b100111);
    chk(capB == 3'b000 && extB == 3'b000, "R11 features B", 32'({capB, extB}), 0);

    // R10 interrupt pass-through
    for (int i = 0; i < 8; i++) begin
      irq_in = NC'(i);
      #1;
      chk(irqA == NC'(i), "R10 irq A", 32'(irqA), 32'(i));
      chk(irqB == NC'(i & 3), "R10 irq B", 32'(irqB), 32'(i & 3));
    end
    irq_in = '0;

    // R6 output control
    for (int k = 0; k < 4; k++) begin
      d = (k[1] ? 32'hFFFF_FFFE : 32'h0) | 32'(k[0]);
      access(1'b1, 0, d, ra, rb);
      ocm = d[0];
      chk(ocA == ocm, "R6 outctl pin", 32'(ocA), 32'(ocm));
      chk(ocB == 1'b0, "R8 outctl absent", 32'(ocB), 0);
      access(1'b0, 0, 0, ra, rb);
      chk(ra == 32'(ocm), "R6 outctl read", ra, 32'(ocm));
      chk(rb == 0, "R8 unmapped read", rb, 0);
    end

    // R4 R5 R7 run-control word
    for (int k = 0; k < 18; k++) begin
      int v;
      v = (k < 16) ? ((k * 7) & 15) : 9;
      d = 32'hA500_0000 | (32'(k) << 8) | 32'(v);
      oldA = stA[2:0]; oldB = stB[2:0];
      access(1'b1, 4, d, ra, rb);
      stA = d;
      stB = d & ~32'd4;
      nA = stA[2:0]; nB = stB[2:0];
      chk(runA == nA, "R4 run A", 32'(runA), 32'(nA));
      chk(runB == nB, "R7 run B", 32'(runB), 32'(nB));
      chk(goA == (nA & ~oldA) && haltA == (oldA & ~nA), "R5 pulses A",
          32'({goA, haltA}), 32'({nA & ~oldA, oldA & ~nA}));
      chk(goB == (nB & ~oldB) && haltB == (oldB & ~nB), "R5 pulses B",
          32'({goB, haltB}), 32'({nB & ~oldB, oldB & ~nB}));
      @(negedge clk);
      chk(goA == 0 && haltA == 0 && goB == 0 && haltB == 0, "R5 one cycle",
          32'({goA, haltA}), 0);
      access(1'b0, 4, 0, ra, rb);
      chk(ra == stA, "R4 readback A", ra, stA);
      chk(rb == stB, "R7 readback B", rb, stB);
    end

    // R2 R3 R7 R8 exhaustive read sweep
    for (int a = 0; a < 256; a++) begin
      access(1'b0, a, 0, ra, rb);
      ea = err_of(a, 1'b1, 1'b1, 1'b0, 0) ? 0 : rd_of(a, 1'b1, 1'b1, stA, 32'h5A00_0000);
      eb = err_of(a, 1'b0, 1'b0, 1'b0, 0) ? 0 : rd_of(a, 1'b0, 1'b0, stB, 32'h3C00_0000);
      chk(ra == ea, "R3 read A", ra, ea);
      chk(rb == eb, "R3 read B", rb, eb);
    end

    // R8 write sweep that must leave all state alone
    for (int a = 1; a < 256; a++) begin
      if (a == 4) continue;
      access(1'b1, a, 32'hFFFF_FFFF, ra, rb);
      chk(ra == 0 && rb == 0, "R8 write rdata", ra, 0);
    end
    chk(runA == stA[2:0] && runB == stB[2:0], "R8 run untouched", 32'(runA), 32'(stA[2:0]));
    chk(ocA == ocm, "R8 outctl untouched", 32'(ocA), 32'(ocm));
    access(1'b0, 4, 0, ra, rb);
    chk(ra == stA && rb == stB, "R8 word untouched", ra, stA);

    // R9 response only for accepted requests
    @(negedge clk);
    chk(!vA && !vB, "R9 no extra rsp", 32'({vA, vB}), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule